// File: doc/BRIEF.md
# Parity-Framed Asynchronous Serial Transmitter

This block turns one parallel byte into an asynchronous serial frame on a single line. A frame is eleven bit periods long: a low start bit, the eight data bits beginning with the least-significant one, a parity bit, and a high stop bit. The block runs from a clock at sixteen times the bit rate and counts sixteen clock cycles for each bit. Producing that 16x clock from a faster system clock is left to the surrounding logic.

A host loads a byte by driving it on `din` and pulling the active-low strobe `wr_n` low. The byte and the parity selection are captured on the falling edge of the strobe. Back-pressure works through `ready`. A falling edge is accepted only while `ready` is high. `ready` goes low on the next cycle and stays low until the stop bit has run for its full sixteen cycles. A falling edge that arrives while `ready` is low is dropped and is not queued. A strobe that is held low does not start another frame. The host must raise it and lower it again after `ready` has returned high. The parity selection input chooses even or odd parity for each frame.

Top module: `uart_ftx`

## Requirements
- R1: While reset is asserted, and whenever no frame is in progress, `txd` is 1 and `ready` is 1.
- R2: An accepted byte is sent as eleven bits in this order: start bit 0, `din[0]` through `din[7]`, the parity bit, and stop bit 1.
- R3: Each bit of the frame holds `txd` constant for exactly 16 clock cycles. The start bit begins in the cycle after the strobe edge is accepted.
- R4: With `odd_par` = 0 the parity bit equals the XOR of the eight data bits (even parity). With `odd_par` = 1 the parity bit is that XOR inverted (odd parity).
- R5: `din` and `odd_par` are captured only at the accepted falling edge of `wr_n`. Changing them later during the frame does not change the bits that are sent.
- R6: `ready` falls in the cycle after an accepted strobe edge. It stays low for exactly 176 cycles and rises once the stop bit has completed its 16 cycles.
- R7: A falling edge of `wr_n` while `ready` is 0 is ignored. The frame in progress is not altered, and no further frame follows it.
- R8: Holding `wr_n` low past the end of a frame does not start another frame. Only a new high-to-low transition is accepted.
- R9: Reset is synchronous and active high. Asserting it in the middle of a frame returns `txd` and `ready` to 1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Active-low write strobe; the falling edge loads a byte |
| din | input | DATA_W | Byte to transmit |
| odd_par | input | 1 | Parity selection: 0 even, 1 odd |
| ready | output | 1 | High when a new byte may be written |
| txd | output | 1 | Serial line output, high when idle |

## Verification
The hardest situations to reach are a strobe edge that arrives in the middle of a busy frame and a strobe held low across the point where `ready` returns. Neither of these changes an output by itself, so a fault shows up only as a frame that is disturbed or an extra frame that appears later. The stimulus pulses `wr_n` forty cycles into a frame while changing `din` and `odd_par`. It also holds the strobe low through a whole frame. In both cases every cycle of the line is compared against the expected frame, and the line is then watched to confirm it stays idle. A reset is also forced fifty cycles into a frame to confirm that the line returns to idle at once.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;
  // overhead bits around the data: start, parity, stop
  localparam int unsigned FRAME_OVERHEAD = 3;

  function automatic int unsigned frame_bits(input int unsigned data_w);
    return data_w + FRAME_OVERHEAD;
  endfunction

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;
endpackage

// File: rtl/uart_ftx_strobe.sv
module uart_ftx_strobe (
  input  logic clk,
  input  logic rst,
  input  logic wr_n,
  output logic fall
);
  logic wr_q;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  assign fall = wr_q & ~wr_n;
endmodule

// File: rtl/uart_ftx_baud.sv
module uart_ftx_baud #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic bit_end
);
  localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt;

  assign bit_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) cnt <= '0;
    else if (bit_end)           cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_ftx_frame.sv
module uart_ftx_frame
  import uart_ftx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              odd_par,
  input  logic              bit_end,
  output logic              busy,
  output logic              txd
);
  localparam int unsigned NBITS = frame_bits(DATA_W);
  localparam int unsigned BW    = $clog2(NBITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(NBITS - 1);

  logic [NBITS-1:0] sh;
  logic [BW-1:0]    bit_idx;
  logic             par;

  always_comb begin
    par = ^data;
    if (par_mode_e'(odd_par) == PAR_ODD) par = ~par;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      sh      <= {1'b1, par, data, 1'b0};
      bit_idx <= '0;
      busy    <= 1'b1;
    end else if (bit_end) begin
      sh <= {1'b1, sh[NBITS-1:1]};
      if (bit_idx == LAST_BIT) begin
        busy    <= 1'b0;
        bit_idx <= '0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  assign txd = sh[0];
endmodule

// File: rtl/uart_ftx.sv
module uart_ftx #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] din,
  input  logic              odd_par,
  output logic              ready,
  output logic              txd
);
  logic fall;
  logic busy;
  logic accept;
  logic bit_end;

  uart_ftx_strobe u_strobe (
    .clk  (clk),
    .rst  (rst),
    .wr_n (wr_n),
    .fall (fall)
  );

  assign accept = fall & ~busy;

  uart_ftx_baud #(.OVERSAMPLE(OVERSAMPLE)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .run     (busy),
    .bit_end (bit_end)
  );

  uart_ftx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .data    (din),
    .odd_par (odd_par),
    .bit_end (bit_end),
    .busy    (busy),
    .txd     (txd)
  );

  assign ready = ~busy;
endmodule

// File: rtl/uart_ftx_chk.sv
module uart_ftx_chk #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned OVERSAMPLE = 16
) (
  input logic clk,
  input logic rst,
  input logic wr_n,
  input logic ready,
  input logic txd
);
  localparam int unsigned FRAME_CYC = OVERSAMPLE * (DATA_W + 3);
  localparam int unsigned LW = $clog2(FRAME_CYC + 1) + 1;

  logic          wr_prev;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1;
      low_cnt <= '0;
    end else begin
      wr_prev <= wr_n;
      low_cnt <= ready ? '0 : low_cnt + 1'b1;
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> txd);

  // R6
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && wr_prev && !wr_n) |=> (!ready && !txd));

  // R6
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && !$past(rst)) |-> (low_cnt == LW'(FRAME_CYC)));

  // R2
  stop_bit_high_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ready) && !$past(rst)) |-> $past(txd));
endmodule

bind uart_ftx uart_ftx_chk #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_n  (wr_n),
  .ready (ready),
  .txd   (txd)
);

// File: tb/test_uart_ftx.sv
module test_uart_ftx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic       odd_par = 1'b0;
  logic       ready;
  logic       txd;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  uart_ftx i_uart_ftx (
    .clk     (clk),
    .rst     (rst),
    .wr_n    (wr_n),
    .din     (din),
    .odd_par (odd_par),
    .ready   (ready),
    .txd     (txd)
  );

  // {data, odd_par, expected parity bit}
  localparam logic [9:0] VEC [0:7] = '{
    {8'hAA, 1'b0, 1'b0},
    {8'hF0, 1'b0, 1'b0},
    {8'hF0, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0},
    {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1},
    {8'h01, 1'b0, 1'b1},
    {8'h80, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic odd, input logic par, input bit poke);
    logic [10:0] exp;
    logic [10:0] mid;
    int bad_line;
    int bad_rdy;
    exp = {1'b1, par, d, 1'b0};
    mid = '0;
    bad_line = 0;
    bad_rdy = 0;
    @(negedge clk);
    din = d; odd_par = odd; wr_n = 1'b0;
    @(posedge clk);
    for (int c = 1; c <= 177; c++) begin
      @(negedge clk);
      if (c == 2) wr_n = 1'b1;
      if (c == 3) begin din = ~d; odd_par = ~odd; end
      if (poke && c == 40) begin wr_n = 1'b0; din = 8'h5A; end
      if (poke && c == 42) wr_n = 1'b1;
      if (c <= 176) begin
        int b;
        b = (c - 1) / 16;
        if (txd !== exp[b]) bad_line++;
        if (ready !== 1'b0) bad_rdy++;
        if ((c - 1) % 16 == 7) mid[b] = txd;
      end else begin
        if (ready !== 1'b1) bad_rdy++;
        if (txd !== 1'b1) bad_line++;
      end
    end
    // R2 R4 R5: mid-bit samples match the frame built from the captured byte
    chk(mid === exp, "R2/R4/R5 frame bits", int'(mid), int'(exp));
    // R3: every cycle of every bit period holds the expected level
    chk(bad_line == 0, "R3 bit duration", bad_line, 0);
    // R6: ready low for 176 cycles then high
    chk(bad_rdy == 0, "R6 ready window", bad_rdy, 0);
    if (poke) begin
      chk(bad_line == 0 && mid === exp, "R7 frame undisturbed", int'(mid), int'(exp));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int idle_bad;
    int low_cyc;
    repeat (3) @(negedge clk);
    // R1: line high and ready while reset is held
    chk(txd === 1'b1 && ready === 1'b1, "R1 during reset", {txd, ready}, 3);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1 && ready === 1'b1, "R1 after reset", {txd, ready}, 3);

    for (int i = 0; i < 8; i++) begin
      send(VEC[i][9:2], VEC[i][1], VEC[i][0], i == 3);
    end

    // R7: no frame queued by the strobe seen while busy
    idle_bad = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (txd !== 1'b1 || ready !== 1'b1) idle_bad++;
    end
    chk(idle_bad == 0, "R7 no trailing frame", idle_bad, 0);

    // R8: strobe held low for a whole frame and beyond
    @(negedge clk);
    din = 8'h3C; odd_par = 1'b0; wr_n = 1'b0;
    low_cyc = 0;
    for (int c = 0; c < 260; c++) begin
      @(negedge clk);
      if (ready === 1'b0) low_cyc++;
    end
    chk(low_cyc == 176, "R8 single frame while held low", low_cyc, 176);
    chk(txd === 1'b1 && ready === 1'b1, "R1 R8 idle after held strobe", {txd, ready}, 3);
    wr_n = 1'b1;

    // R9: reset in the middle of a frame
    @(negedge clk);
    din = 8'h00; wr_n = 1'b0;
    repeat (50) @(negedge clk);
    wr_n = 1'b1;
    chk(txd === 1'b0 && ready === 1'b0, "R9 busy before reset", {txd, ready}, 0);
    rst = 1'b1;
    @(negedge clk);
    chk(txd === 1'b1 && ready === 1'b1, "R9 reset mid-frame", {txd, ready}, 3);
    rst = 1'b0;
    @(negedge clk);
    // R9: normal frame after recovery
    send(8'hC3, 1'b1, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule